// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between an SDRAM command generator and the memory command bus. The generator presents one command at a time with a linear host address. The guard holds the command back until every timing window that applies to it has closed, and then issues it on a registered command bus. The address is split into row, bank and column fields for a chosen device geometry.

Five timing settings are programmable through a small write-only configuration port:

- self-refresh exit to activate;
- activate to activate on a different bank;
- mode-register load to activate;
- activate to read/write (RAS latency);
- read to write turnaround (CAS latency).

Each delay field encodes n+1 clocks. A held command raises `stall` in the same cycle. The generator keeps the command on its inputs while stalled, so no command is ever lost or reordered.

Command codes on `req_cmd`/`cmd_code`:

| Code | Command |
|------|---------|
| 0 | NOP |
| 1 | ACTIVATE |
| 2 | READ |
| 3 | WRITE |
| 4 | LOAD MODE |
| 5 | SELF-REFRESH EXIT |
| 6 | PRECHARGE |
| 7 | reserved |

Configuration addresses on `cfg_addr`:

| Address | Setting |
|---------|---------|
| 0 | exit delay (5 bit) |
| 1 | bank-to-bank delay (4 bit) |
| 2 | mode-load delay (4 bit) |
| 3 | geometry (5 bit) |
| 4 | RAS latency (2 bit) |
| 5 | CAS latency (2 bit) |

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset, `cmd_valid` and `stall` are low. The defaults are: exit delay code 9, bank-to-bank code 1, mode-load code 0, RAS and CAS latency code 3, geometry code 00101.
- R2: An ACTIVATE that follows a SELF-REFRESH EXIT issues no earlier than code+1 clocks after it. This gives 1 to 31 clocks for codes 0 to 30, and 32 clocks for code 31.
- R3: An ACTIVATE to a bank other than the last activated bank issues no earlier than code+1 clocks after that activate, with code 15 giving 16 clocks. An ACTIVATE to the same bank is not held by this window.
- R4: An ACTIVATE that follows a LOAD MODE issues no earlier than code+1 clocks after it. Code 0 allows back-to-back issue.
- R5: A READ or WRITE issues no earlier than L clocks after the last ACTIVATE. The 2-bit RAS code gives L: 01 gives 1, 10 gives 2, 11 gives 3, and reserved 00 is treated as 3.
- R6: A WRITE issues no earlier than L clocks after the last READ. L comes from the 2-bit CAS code with the same encoding as R5, including 00 treated as 3.
- R7: While a presented command is blocked, `stall` is high in that same cycle. A command is issued exactly once, in request order, with `cmd_valid` high in the cycle after it is accepted. `stall` stays low whenever `req_valid` is low.
- R8: The address is split with the column in the low bits, the bank above it and the row above the bank. Code 00001 gives 8-bit column, 1-bit bank, 11-bit row. Code 00101 gives 8/2/12. Code 01001 gives 9/2/12.
- R9: A geometry code that is not listed in R8 splits the address as code 00101 does.
- R10: PRECHARGE, NOP and READ are never held by the write-turnaround window. A READ after a READ issues back-to-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration setting select |
| cfg_data | input | 5 | Configuration write value |
| req_valid | input | 1 | A command is presented |
| req_cmd | input | 3 | Presented command code |
| req_addr | input | 23 | Linear host address |
| stall | output | 1 | Presented command is held this cycle |
| cmd_valid | output | 1 | Issued command valid |
| cmd_code | output | 3 | Issued command code |
| cmd_row | output | 12 | Issued row address |
| cmd_bank | output | 2 | Issued bank address |
| cmd_col | output | 9 | Issued column address |

## Verification
The bench goes after the edges of each encoding:

- Exit code 31 must give 32 clocks, not 31 or 0.
- Bank-to-bank code 15 must give 16 clocks.
- Reserved latency code 00 must wait three clocks. A design that decoded it as zero would release a READ or WRITE at once.

It also activates the same bank twice in a row. A design that ignored the bank comparison would hold that second activate.

The scoreboard catches two further failure classes. A dropped or duplicated command while stalled leaves the expected queue out of step. A mis-shifted geometry (wrong column width, or an undefined code not falling back) puts bits in the wrong field.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_MRS = 3'd4,
    CMD_SRX = 3'd5,
    CMD_PRE = 3'd6,
    CMD_RSV = 3'd7
  } guard_cmd_e;

  localparam logic [2:0] CFG_XSR = 3'd0;
  localparam logic [2:0] CFG_RRD = 3'd1;
  localparam logic [2:0] CFG_MRD = 3'd2;
  localparam logic [2:0] CFG_GEO = 3'd3;
  localparam logic [2:0] CFG_RAS = 3'd4;
  localparam logic [2:0] CFG_CAS = 3'd5;

  localparam logic [4:0] GEO_2B_R11_C8 = 5'b00001;
  localparam logic [4:0] GEO_4B_R12_C8 = 5'b00101;
  localparam logic [4:0] GEO_4B_R12_C9 = 5'b01001;

endpackage

// File: rtl/sdram_guard_regs.sv
module sdram_guard_regs #(
  parameter int XSR_W   = 5,
  parameter int DLY_W   = 4,
  parameter int LAT_W   = 2,
  parameter int GEO_W   = 5,
  parameter int CFG_AW  = 3,
  parameter int CFG_DW  = 5,
  parameter logic [XSR_W-1:0] XSR_RST = 9,
  parameter logic [DLY_W-1:0] RRD_RST = 1,
  parameter logic [DLY_W-1:0] MRD_RST = 0,
  parameter logic [LAT_W-1:0] LAT_RST = 3,
  parameter logic [GEO_W-1:0] GEO_RST = 5'b00101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  output logic [XSR_W-1:0]  xsr_load,
  output logic [DLY_W-1:0]  rrd_load,
  output logic [DLY_W-1:0]  mrd_load,
  output logic [LAT_W-1:0]  ras_load,
  output logic [LAT_W-1:0]  cas_load,
  output logic [GEO_W-1:0]  geo_code
);
  import sdram_guard_pkg::*;

  logic [XSR_W-1:0] xsr_q;
  logic [DLY_W-1:0] rrd_q, mrd_q;
  logic [LAT_W-1:0] ras_q, cas_q;
  logic [GEO_W-1:0] geo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xsr_q <= XSR_RST;
      rrd_q <= RRD_RST;
      mrd_q <= MRD_RST;
      ras_q <= LAT_RST;
      cas_q <= LAT_RST;
      geo_q <= GEO_RST;
    end else if (cfg_wr) begin
      case (cfg_addr)
        CFG_XSR: xsr_q <= cfg_data[XSR_W-1:0];
        CFG_RRD: rrd_q <= cfg_data[DLY_W-1:0];
        CFG_MRD: mrd_q <= cfg_data[DLY_W-1:0];
        CFG_GEO: geo_q <= cfg_data[GEO_W-1:0];
        CFG_RAS: ras_q <= cfg_data[LAT_W-1:0];
        CFG_CAS: cas_q <= cfg_data[LAT_W-1:0];
        default: ;
      endcase
    end
  end

  // A code of n means n+1 clocks, so the countdown preload is the code itself.
  // Latency codes mean L clocks (00 reserved -> max), so the preload is L-1.
  function automatic logic [LAT_W-1:0] lat_preload(input logic [LAT_W-1:0] code);
    return (code == '0) ? ({LAT_W{1'b1}} - 1'b1) : (code - 1'b1);
  endfunction

  assign xsr_load = xsr_q;
  assign rrd_load = rrd_q;
  assign mrd_load = mrd_q;
  assign ras_load = lat_preload(ras_q);
  assign cas_load = lat_preload(cas_q);
  assign geo_code = geo_q;

  assert_lat_preload_R5: assert property (@(posedge clk) disable iff (rst)
    (ras_load != {LAT_W{1'b1}}) && (cas_load != {LAT_W{1'b1}}));

endmodule

// File: rtl/sdram_guard_ctr.sv
module sdram_guard_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  assert_ctr_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

  assert_ctr_countdown_R2: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdram_guard_split.sv
module sdram_guard_split #(
  parameter int ROW_W = 12,
  parameter int BANK_W = 2,
  parameter int COL_W = 9,
  parameter int GEO_W = 5,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [GEO_W-1:0]  geo,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col
);
  import sdram_guard_pkg::*;

  logic [4:0] cb, bb, rb;
  logic [ADDR_W-1:0] col_f, bank_f, row_f;

  always_comb begin
    case (geo)
      GEO_2B_R11_C8: begin cb = 5'd8; bb = 5'd1; rb = 5'd11; end
      GEO_4B_R12_C9: begin cb = 5'd9; bb = 5'd2; rb = 5'd12; end
      default:       begin cb = 5'd8; bb = 5'd2; rb = 5'd12; end
    endcase
    col_f  = addr & ~({ADDR_W{1'b1}} << cb);
    bank_f = (addr >> cb) & ~({ADDR_W{1'b1}} << bb);
    row_f  = (addr >> (cb + bb)) & ~({ADDR_W{1'b1}} << rb);
  end

  assign col  = col_f[COL_W-1:0];
  assign bank = bank_f[BANK_W-1:0];
  assign row  = row_f[ROW_W-1:0];

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int XSR_W  = 5,
  parameter int DLY_W  = 4,
  parameter int LAT_W  = 2,
  parameter int GEO_W  = 5,
  parameter int CFG_AW = 3,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W,
  localparam int CFG_DW = (XSR_W > GEO_W) ? XSR_W : GEO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              stall,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col
);
  import sdram_guard_pkg::*;

  logic [XSR_W-1:0]  xsr_load;
  logic [DLY_W-1:0]  rrd_load, mrd_load;
  logic [LAT_W-1:0]  ras_load, cas_load;
  logic [GEO_W-1:0]  geo_code;
  logic [ROW_W-1:0]  s_row;
  logic [BANK_W-1:0] s_bank;
  logic [COL_W-1:0]  s_col;
  logic [BANK_W-1:0] last_bank;
  logic busy_xsr, busy_rrd, busy_mrd, busy_ras, busy_cas;
  logic blocked, accept;
  logic is_act, is_rd, is_wr, is_mrs, is_srx;

  sdram_guard_regs #(
    .XSR_W(XSR_W), .DLY_W(DLY_W), .LAT_W(LAT_W), .GEO_W(GEO_W),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) regs_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .xsr_load(xsr_load), .rrd_load(rrd_load), .mrd_load(mrd_load),
    .ras_load(ras_load), .cas_load(cas_load), .geo_code(geo_code)
  );

  sdram_guard_split #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .GEO_W(GEO_W)
  ) split_i (
    .addr(req_addr), .geo(geo_code), .row(s_row), .bank(s_bank), .col(s_col)
  );

  assign is_act = (req_cmd == CMD_ACT);
  assign is_rd  = (req_cmd == CMD_RD);
  assign is_wr  = (req_cmd == CMD_WR);
  assign is_mrs = (req_cmd == CMD_MRS);
  assign is_srx = (req_cmd == CMD_SRX);

  sdram_guard_ctr #(.W(XSR_W)) xsr_ctr_i (.clk(clk), .rst(rst),
    .load(accept && is_srx), .load_val(xsr_load), .busy(busy_xsr));
  sdram_guard_ctr #(.W(DLY_W)) rrd_ctr_i (.clk(clk), .rst(rst),
    .load(accept && is_act), .load_val(rrd_load), .busy(busy_rrd));
  sdram_guard_ctr #(.W(DLY_W)) mrd_ctr_i (.clk(clk), .rst(rst),
    .load(accept && is_mrs), .load_val(mrd_load), .busy(busy_mrd));
  sdram_guard_ctr #(.W(LAT_W)) ras_ctr_i (.clk(clk), .rst(rst),
    .load(accept && is_act), .load_val(ras_load), .busy(busy_ras));
  sdram_guard_ctr #(.W(LAT_W)) cas_ctr_i (.clk(clk), .rst(rst),
    .load(accept && is_rd), .load_val(cas_load), .busy(busy_cas));

  always_comb begin
    blocked = 1'b0;
    if (is_act) blocked = busy_xsr || busy_mrd || (busy_rrd && (s_bank != last_bank));
    if (is_rd)  blocked = busy_ras;
    if (is_wr)  blocked = busy_ras || busy_cas;
  end

  assign stall  = req_valid && blocked;
  assign accept = req_valid && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_NOP;
      cmd_row   <= '0;
      cmd_bank  <= '0;
      cmd_col   <= '0;
      last_bank <= '0;
    end else begin
      cmd_valid <= accept;
      if (accept) begin
        cmd_code <= req_cmd;
        cmd_row  <= s_row;
        cmd_bank <= s_bank;
        cmd_col  <= s_col;
      end
      if (accept && is_act) last_bank <= s_bank;
    end
  end

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> !cmd_valid);

  assert_accept_issues_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !stall) |=> (cmd_valid && cmd_code == $past(req_cmd)));

  assert_idle_no_stall_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !stall);

  assert_srx_guard_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_SRX && xsr_load != '0) |->
      !(req_valid && is_act && !stall));

endmodule

// File: tb/sdram_cmd_guard_tb_top.sv
module sdram_cmd_guard_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [4:0] cfg_data = '0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [22:0] req_addr = '0;
  logic stall, cmd_valid;
  logic [2:0] cmd_code;
  logic [11:0] cmd_row;
  logic [1:0] cmd_bank;
  logic [8:0] cmd_col;

  always #10 clk = ~clk;

  sdram_cmd_guard dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .stall(stall), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_row(cmd_row), .cmd_bank(cmd_bank), .cmd_col(cmd_col)
  );

  typedef struct {
    logic [2:0]  c;
    logic [11:0] r;
    logic [1:0]  b;
    logic [8:0]  col;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  logic [4:0] tb_geo = 5'b00101;
  bit done = 1'b0;

  localparam logic [2:0] ACT = 3'd1, RD = 3'd2, WR = 3'd3, MRS = 3'd4, SRX = 3'd5, PRE = 3'd6;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t split(input logic [2:0] c, input logic [22:0] a);
    exp_t e;
    e.c = c;
    case (tb_geo)
      5'b00001: begin e.col = {1'b0, a[7:0]}; e.b = {1'b0, a[8]}; e.r = {1'b0, a[19:9]}; end
      5'b01001: begin e.col = a[8:0]; e.b = a[10:9]; e.r = a[22:11]; end
      default:  begin e.col = {1'b0, a[7:0]}; e.b = a[9:8]; e.r = a[21:10]; end
    endcase
    return e;
  endfunction

  // default geometry address builder: row | bank | col(8)
  function automatic logic [22:0] mk(input logic [11:0] r, input logic [1:0] b, input logic [7:0] c);
    return {1'b0, r, b, c};
  endfunction

  task automatic send(input logic [2:0] c, input logic [22:0] a, input int exp_w, input string req);
    int w;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a;
    exp_q.push_back(split(c, a));
    #1;
    w = 0;
    while (stall === 1'b1 && w < 100) begin
      w++;
      @(negedge clk);
      #1;
    end
    chk(w == exp_w, req, "stall cycles", w, exp_w);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] a, input logic [4:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
    if (a == 3'd3) tb_geo = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected command", int'(cmd_code), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (cmd_code !== e.c || cmd_row !== e.r || cmd_bank !== e.b || cmd_col !== e.col) begin
          failures++;
          $display("FAIL R7/R8 issued cmd actual=%h/%h/%h/%h expected=%h/%h/%h/%h",
                   cmd_code, cmd_row, cmd_bank, cmd_col, e.c, e.r, e.b, e.col);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid === 1'b0, "R1", "cmd_valid in reset", int'(cmd_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_valid === 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
    chk(stall === 1'b0, "R1", "stall after reset", int'(stall), 0);

    // Defaults: exit 9, rrd 1, mrd 0, ras 3, cas 3
    send(SRX, mk(12'h0, 2'd0, 8'h0), 0, "R2");
    idle(1);
    chk(stall === 1'b0, "R7", "stall with no request", int'(stall), 0);
    send(ACT, mk(12'h123, 2'd0, 8'h00), 8, "R1 R2 default exit");
    send(ACT, mk(12'h456, 2'd1, 8'h00), 1, "R1 R3 default rrd");
    send(ACT, mk(12'h457, 2'd1, 8'h00), 0, "R3 same bank");
    send(RD,  mk(12'h457, 2'd1, 8'h3C), 2, "R1 R5 default ras");
    send(WR,  mk(12'h457, 2'd1, 8'h3D), 2, "R1 R6 default cas");
    send(PRE, mk(12'h0, 2'd1, 8'h0), 0, "R10 precharge");
    send(RD,  mk(12'hABC, 2'd3, 8'h11), 0, "R10 read");
    send(RD,  mk(12'hABC, 2'd3, 8'h12), 0, "R10 read after read");
    send(MRS, mk(12'h033, 2'd0, 8'h0), 0, "R4");
    send(ACT, mk(12'h777, 2'd2, 8'h0), 0, "R1 R4 default mrd");
    idle(40);

    // Extremes: exit 31 -> 32 clocks, rrd 15 -> 16, mrd 6 -> 7, ras reserved, cas 1
    cfg(3'd0, 5'd31);
    cfg(3'd1, 5'd15);
    cfg(3'd2, 5'd6);
    cfg(3'd4, 5'd0);
    cfg(3'd5, 5'd1);
    send(SRX, mk(12'h0, 2'd0, 8'h0), 0, "R2");
    send(ACT, mk(12'h100, 2'd2, 8'h0), 31, "R2 code 31");
    send(ACT, mk(12'h200, 2'd3, 8'h0), 15, "R3 code 15");
    send(MRS, mk(12'h0, 2'd0, 8'h0), 0, "R4");
    send(ACT, mk(12'h201, 2'd3, 8'h0), 6, "R4 code 6");
    send(RD,  mk(12'h201, 2'd3, 8'h40), 2, "R5 reserved 00");
    send(WR,  mk(12'h201, 2'd3, 8'h41), 0, "R6 code 01");
    idle(40);

    cfg(3'd4, 5'd2);
    cfg(3'd5, 5'd2);
    send(ACT, mk(12'h300, 2'd0, 8'h0), 0, "R3");
    send(RD,  mk(12'h300, 2'd0, 8'h5), 1, "R5 code 10");
    send(WR,  mk(12'h300, 2'd0, 8'h6), 1, "R6 code 10");
    idle(10);
    cfg(3'd4, 5'd1);
    cfg(3'd5, 5'd0);
    send(ACT, mk(12'h301, 2'd1, 8'h0), 0, "R3");
    send(RD,  mk(12'h301, 2'd1, 8'h7), 0, "R5 code 01");
    send(WR,  mk(12'h301, 2'd1, 8'h8), 2, "R6 reserved 00");
    idle(10);

    // Geometry (R8, R9), checked by the scoreboard
    send(PRE, 23'h3F_A5C3, 0, "R8 default");
    cfg(3'd3, 5'b00001);
    send(PRE, 23'h5A_B1E7, 0, "R8 2 banks");
    cfg(3'd3, 5'b01001);
    send(PRE, 23'h7D_35A9, 0, "R8 9-bit column");
    cfg(3'd3, 5'b00111);
    send(PRE, 23'h6C_9F31, 0, "R9 undefined code");
    cfg(3'd3, 5'b00000);
    send(PRE, 23'h12_3456, 0, "R9 zero code");

    idle(5);
    chk(exp_q.size() == 0, "R7", "commands left unissued", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule